// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Interface Master

This block is a serial peripheral interface (SPI) master that software drives through five 32-bit word registers: control, event, interrupt enable, transmit data and receive data. Software first programs the character width, the prescaler, the bit order and the loopback option while the block is disabled. It then sets the enable bit and writes one character to the transmit register. The block shifts that character out on MOSI and samples MISO at the same time. When the last bit completes, it posts the received character and raises two event flags.

Events stay set until software writes a one to them. A per-event enable mask combines the events into a single level-sensitive interrupt. Chip selects are not part of this block; the surrounding logic drives them. Loopback feeds the outgoing serial stream back into the receive shifter, so the data path can be tested with no device attached.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset all registers read zero, `irq_o` is 0, and `sck_o` and `mosi_o` are low.
- R2: Word address 0 is control, 1 is events, 2 is interrupt enable, 3 is transmit and 4 is receive. The control fields are: loopback at bit 30, most-significant-first at bit 26, master at bit 25, enable at bit 24, the length code at bits 23:20 and the prescaler at bits 19:16. All other control bits read zero.
- R3: The length code selects the character width. Code 0 selects 32 bits, codes 4 to 15 select code+1 bits, and codes 1 to 3 select 4 bits.
- R4: With bit 26 set, the character is shifted most-significant bit first. With bit 26 clear, it is shifted least-significant bit first. Both directions use the same bit order.
- R5: The transmitted character is taken from the low bits of the transmit word. The received character is returned in the low bits of the receive register, with the unused upper bits zero.
- R6: At the end of a transfer, receive-ready (event bit 9) and transmit-free (event bit 8) are both set. Writing a 1 to an event bit clears it, and writing a 0 leaves it unchanged.
- R7: With loopback set, the receive shifter samples the outgoing bit and ignores `miso_i`.
- R8: The SCK period is 4×(prescaler+1) system clocks. SCK idles low, each bit is launched while SCK is low, and each bit is sampled on the rising SCK edge.
- R9: `irq_o` is the OR of the event bits (12, 9, 8) ANDed with the same bits of the interrupt-enable register.
- R10: If a transfer completes while receive-ready is still set, overrun (event bit 12) is set and the receive register takes the new character.
- R11: While enable is 1, writes to the length code and prescaler fields are ignored.
- R12: Clearing enable during a transfer stops it within one clock. SCK returns low and no event is raised.
- R13: A transmit write is ignored if the block is disabled or a transfer is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_cs_i | input | 1 | Register access select |
| reg_we_i | input | 1 | Write strobe (1 = write, 0 = read) |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Masked event interrupt |

## Verification
The bench sweeps every length code in both bit orders against a slave model, so a wrong width, a reversed order or a left-justified result shows up as a mismatch in the received word or the captured MOSI stream. It measures SCK rising-edge spacing for several prescaler values; an off-by-one divider gives the wrong period. It also targets the flag corners. A single-bit clear that wipes the other flags, an overrun that is missed when a second character lands, or an interrupt that ignores the mask all show up in register reads. Aborting mid-transfer, and writing transmit data while disabled or busy, must leave SCK quiet and the flags clear; a design that keeps shifting or starts anyway fails these checks.

// File: rtl/spi_host_pkg.sv
// Shared types and constants for the SPI host controller.
// Assumes a 32-bit register word and a 4-bit length code.
package spi_host_pkg;

    localparam int WORD_W = 32;
    localparam int CODE_W = 4;

    // Word addresses of the register file.
    localparam logic [2:0] RA_CTL = 3'd0;
    localparam logic [2:0] RA_EVT = 3'd1;
    localparam logic [2:0] RA_IEN = 3'd2;
    localparam logic [2:0] RA_TXD = 3'd3;
    localparam logic [2:0] RA_RXD = 3'd4;

    // Control and event bit positions.
    localparam int B_LOOP = 30;
    localparam int B_MSBF = 26;
    localparam int B_MSTR = 25;
    localparam int B_EN   = 24;
    localparam int B_LEN  = 20;
    localparam int B_PRE  = 16;
    localparam int B_OVR  = 12;
    localparam int B_RNE  = 9;
    localparam int B_TNF  = 8;

    // Decoded control register contents.
    typedef struct packed {
        logic              loop;
        logic              msbf;
        logic              mstr;
        logic              en;
        logic [CODE_W-1:0] len;
        logic [CODE_W-1:0] pre;
    } ctl_t;

    // Event flags as held in the register file.
    typedef struct packed {
        logic ovr;
        logic rne;
        logic tnf;
    } evt_t;

endpackage

// File: rtl/spi_host_clkdiv.sv
// Half-period tick generator for SCK.
// Emits one tick every 2*(pre+1) clocks while run is high and restarts
// from zero whenever run is low, so the first tick after a transfer
// starts always arrives a full half period later.
module spi_host_clkdiv #(
    parameter int PRE_W = 4,
    localparam int CNT_W = PRE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_w;

    // Terminal count of one half period is 2*pre+1.
    assign last_w = {pre, 1'b1};
    assign tick   = run && (cnt_q == last_w);

    // Counts clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_host_shift.sv
// Serial shift engine. On start it loads the character and drives the
// first bit with SCK low. Each tick toggles SCK: a rising SCK samples the
// input, and a falling SCK either advances to the next bit or ends the
// transfer with a one-cycle done pulse. Dropping en aborts at once.
// Assumes nbits lies between 4 and DW while a transfer runs.
module spi_host_shift #(
    parameter int DW = 32,
    localparam int LEN_W = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          tick,
    input  logic          msbf,
    input  logic          loop,
    input  logic [LEN_W:0] nbits,
    input  logic [DW-1:0] tx_word,
    input  logic          miso,
    output logic          sck,
    output logic          mosi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_word
);

    localparam logic [LEN_W:0] DW_L = (LEN_W + 1)'(DW);

    logic [DW-1:0]    tx_sh_q;
    logic [DW-1:0]    rx_sh_q;
    logic [LEN_W-1:0] bit_q;
    logic             msbf_q;
    logic             loop_q;
    logic             sck_q;
    logic             busy_q;
    logic             done_q;
    logic             out_bit;
    logic             in_bit;
    logic [LEN_W:0]   pad_w;
    logic [LEN_W-1:0] last_bit;

    assign pad_w    = DW_L - nbits;
    assign last_bit = LEN_W'(nbits - 1'b1);
    assign out_bit  = msbf_q ? tx_sh_q[DW-1] : tx_sh_q[0];
    assign in_bit   = loop_q ? out_bit : miso;

    // Sequences bits, SCK and the shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            bit_q   <= '0;
            msbf_q  <= 1'b0;
            loop_q  <= 1'b0;
            sck_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                busy_q <= 1'b0;
                sck_q  <= 1'b0;
            end else if (start && !busy_q) begin
                busy_q  <= 1'b1;
                sck_q   <= 1'b0;
                bit_q   <= '0;
                msbf_q  <= msbf;
                loop_q  <= loop;
                rx_sh_q <= '0;
                tx_sh_q <= msbf ? (tx_word << pad_w) : tx_word;
            end else if (busy_q && tick) begin
                if (!sck_q) begin
                    sck_q   <= 1'b1;
                    rx_sh_q <= msbf_q ? {rx_sh_q[DW-2:0], in_bit}
                                      : {in_bit, rx_sh_q[DW-1:1]};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == last_bit) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q   <= bit_q + 1'b1;
                        tx_sh_q <= msbf_q ? (tx_sh_q << 1) : (tx_sh_q >> 1);
                    end
                end
            end
        end
    end

    // Right-justifies the received character.
    always_comb begin
        if (msbf_q) begin
            rx_word = rx_sh_q;
        end else begin
            rx_word = rx_sh_q >> pad_w;
        end
    end

    assign sck  = sck_q;
    assign mosi = busy_q && out_bit;
    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/spi_host_regs.sv
// Register file: control, events, interrupt enable, transmit, receive.
// Writes are single-cycle strobes. Reads are combinational from the
// address. Event set by done wins over a write-one clear in the same cycle.
// Assumes one access per cycle.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx_word,
    output ctl_t          ctl,
    output evt_t          evt,
    output evt_t          ien,
    output logic [DW-1:0] tx_word,
    output logic          start,
    output logic          irq
);

    logic    wr_ctl, wr_evt, wr_ien, wr_txd;
    ctl_t    ctl_q;
    evt_t    evt_q, ien_q, clr_w;
    logic [DW-1:0] tx_q, rx_q;

    assign wr_ctl = cs && we && (addr == AW'(RA_CTL));
    assign wr_evt = cs && we && (addr == AW'(RA_EVT));
    assign wr_ien = cs && we && (addr == AW'(RA_IEN));
    assign wr_txd = cs && we && (addr == AW'(RA_TXD));
    assign start  = wr_txd && ctl_q.en && !busy;

    assign clr_w.ovr = wr_evt && wdata[B_OVR];
    assign clr_w.rne = wr_evt && wdata[B_RNE];
    assign clr_w.tnf = wr_evt && wdata[B_TNF];

    // Holds control fields; length and prescaler locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q.loop <= wdata[B_LOOP];
            ctl_q.msbf <= wdata[B_MSBF];
            ctl_q.mstr <= wdata[B_MSTR];
            ctl_q.en   <= wdata[B_EN];
            if (!ctl_q.en) begin
                ctl_q.len <= wdata[B_LEN +: CODE_W];
                ctl_q.pre <= wdata[B_PRE +: CODE_W];
            end
        end
    end

    // Sets events on done, clears them on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q.rne <= (evt_q.rne && !clr_w.rne) || done;
            evt_q.tnf <= (evt_q.tnf && !clr_w.tnf) || done;
            evt_q.ovr <= (evt_q.ovr && !clr_w.ovr) || (done && evt_q.rne);
        end
    end

    // Holds the interrupt enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= '{ovr: wdata[B_OVR], rne: wdata[B_RNE], tnf: wdata[B_TNF]};
        end
    end

    // Captures the accepted transmit word and the received character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (start) begin
                tx_q <= wdata;
            end
            if (done) begin
                rx_q <= rx_word;
            end
        end
    end

    // Selects read data by word address.
    always_comb begin
        rdata = '0;
        case (addr)
            AW'(RA_CTL): begin
                rdata[B_LOOP]             = ctl_q.loop;
                rdata[B_MSBF]             = ctl_q.msbf;
                rdata[B_MSTR]             = ctl_q.mstr;
                rdata[B_EN]               = ctl_q.en;
                rdata[B_LEN +: CODE_W]    = ctl_q.len;
                rdata[B_PRE +: CODE_W]    = ctl_q.pre;
            end
            AW'(RA_EVT): begin
                rdata[B_OVR] = evt_q.ovr;
                rdata[B_RNE] = evt_q.rne;
                rdata[B_TNF] = evt_q.tnf;
            end
            AW'(RA_IEN): begin
                rdata[B_OVR] = ien_q.ovr;
                rdata[B_RNE] = ien_q.rne;
                rdata[B_TNF] = ien_q.tnf;
            end
            AW'(RA_TXD): rdata = tx_q;
            AW'(RA_RXD): rdata = rx_q;
            default:     rdata = '0;
        endcase
    end

    assign irq     = |(evt_q & ien_q);
    assign ctl     = ctl_q;
    assign evt     = evt_q;
    assign ien     = ien_q;
    assign tx_word = tx_q;

endmodule

// File: rtl/spi_host_ctrl.sv
// Top of the SPI host controller: register file, SCK divider and shift
// engine. Decodes the compressed length code into a bit count. Assumes
// a synchronous active-low reset and a single system clock.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = 3,
    localparam int LEN_W = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_cs_i,
    input  logic          reg_we_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          sck_o,
    output logic          mosi_o,
    input  logic          miso_i,
    output logic          irq_o
);

    ctl_t           ctl_w;
    evt_t           evt_w;
    evt_t           ien_w;
    logic [DW-1:0]  tx_w;
    logic [DW-1:0]  rx_w;
    logic           start_w;
    logic           busy_w;
    logic           done_w;
    logic           tick_w;
    logic [LEN_W:0] nbits_w;

    // Maps the length code to a bit count (0 -> full word, <=3 -> 4).
    always_comb begin
        if (ctl_w.len == '0) begin
            nbits_w = (LEN_W + 1)'(DW);
        end else if (ctl_w.len <= CODE_W'(3)) begin
            nbits_w = (LEN_W + 1)'(4);
        end else begin
            nbits_w = (LEN_W + 1)'(ctl_w.len) + 1'b1;
        end
    end

    spi_host_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (reg_cs_i),
        .we      (reg_we_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .rdata   (reg_rdata_o),
        .busy    (busy_w),
        .done    (done_w),
        .rx_word (rx_w),
        .ctl     (ctl_w),
        .evt     (evt_w),
        .ien     (ien_w),
        .tx_word (tx_w),
        .start   (start_w),
        .irq     (irq_o)
    );

    spi_host_clkdiv #(.PRE_W(CODE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .pre   (ctl_w.pre),
        .tick  (tick_w)
    );

    spi_host_shift #(.DW(DW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctl_w.en),
        .start   (start_w),
        .tick    (tick_w),
        .msbf    (ctl_w.msbf),
        .loop    (ctl_w.loop),
        .nbits   (nbits_w),
        .tx_word (reg_wdata_i),
        .miso    (miso_i),
        .sck     (sck_o),
        .mosi    (mosi_o),
        .busy    (busy_w),
        .done    (done_w),
        .rx_word (rx_w)
    );

endmodule

// File: rtl/spi_host_chk.sv
// Property checker for spi_host_ctrl, attached by bind. Watches the
// enable, busy and done handshakes between the sub-blocks against the
// serial pins, the event flags and the interrupt.
module spi_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       busy,
    input logic       done,
    input logic       sck,
    input logic       mosi,
    input logic       irq,
    input logic [2:0] evt,
    input logic [2:0] ien,
    input logic [3:0] len,
    input logic [3:0] pre
);

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck) else $error("sck high while idle"); // R8
    AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mosi) else $error("mosi high while idle"); // R8
    AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) done |=> (evt[1] && evt[0])) else $error("flags not set after done"); // R6
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (done && evt[1]) |=> evt[2]) else $error("overrun missed"); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ien == 3'b000) |-> !irq) else $error("irq with zero mask"); // R9
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (en && $past(en)) |-> ($stable(len) && $stable(pre))) else $error("config changed while enabled"); // R11
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !busy) else $error("busy after disable"); // R12

endmodule

bind spi_host_ctrl spi_host_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctl_w.en),
    .busy (busy_w),
    .done (done_w),
    .sck  (sck_o),
    .mosi (mosi_o),
    .irq  (irq_o),
    .evt  (evt_w),
    .ien  (ien_w),
    .len  (ctl_w.len),
    .pre  (ctl_w.pre)
);

// File: tb/tb_spi_host_ctrl.sv
module tb_spi_host_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, miso, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_host_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_cs_i(cs), .reg_we_i(we),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .irq_o(irq)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(negedge clk) cyc++;

    // Slave model: presents a word bit by bit and captures MOSI on rising SCK.
    logic [31:0] s_word = '0, cap_w = '0;
    logic        s_msbf = 1'b1;
    int          s_len = 32, rise_cnt = 0, t_prev = 0, t_last = 0;

    always @(posedge sck) begin
        if (s_msbf) cap_w = {cap_w[30:0], mosi};
        else if (rise_cnt < 32) cap_w[rise_cnt] = mosi;
        rise_cnt++;
        t_prev = t_last;
        t_last = cyc;
    end

    assign miso = (rise_cnt < s_len) ?
                  (s_msbf ? s_word[s_len-1-rise_cnt] : s_word[rise_cnt]) : 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); cs = 1; we = 1; addr = 3'(a); wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); cs = 1; we = 0; addr = 3'(a);
        #1 d = rdata;
        cs = 0;
    endtask

    function automatic logic [31:0] mw(input bit lp, input bit mf, input bit en, input int code, input int pre);
        return (32'(lp) << 30) | (32'(mf) << 26) | (32'd1 << 25) | (32'(en) << 24) |
               (32'(code) << 20) | (32'(pre) << 16);
    endfunction

    function automatic int len_of(input int code);
        return (code == 0) ? 32 : ((code <= 3) ? 4 : code + 1);
    endfunction

    function automatic logic [31:0] msk(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    endfunction

    task automatic arm(input logic [31:0] w, input bit mf, input int n);
        rise_cnt = 0; cap_w = '0; s_word = w; s_msbf = mf; s_len = n;
    endtask

    task automatic wait_rne();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(1, v);
            if (v[9]) break;
        end
    endtask

    task automatic setup(input bit lp, input bit mf, input int code, input int pre);
        wr(0, mw(lp, mf, 0, code, pre));
        wr(0, mw(lp, mf, 1, code, pre));
        wr(1, 32'hFFFF_FFFF);
    endtask

    // One full transfer, then checks the result word, the MOSI stream and the flags.
    task automatic xfer(input bit lp, input bit mf, input int code, input int pre,
                        input logic [31:0] tx, input logic [31:0] sw);
        logic [31:0] v, e;
        int n;
        n = len_of(code);
        setup(lp, mf, code, pre);
        arm(sw, mf, n);
        wr(3, tx);
        wait_rne();
        rd(4, v);
        e = (lp ? tx : sw) & msk(n);
        chk(v == e, lp ? "R7 loopback rx" : "R3 R4 R5 rx word", v, e);
        chk(cap_w == (tx & msk(n)), "R4 R5 mosi stream", cap_w, tx & msk(n));
        rd(1, v);
        chk(v == 32'h300, "R6 flags after transfer", v, 32'h300);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, tx;
        int rc;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk(v == 0, "R1 register reset", v, 0);
        end
        chk(!irq && !sck && !mosi, "R1 pins reset", {irq, sck, mosi}, 0);

        // R2 field placement and reserved bits
        wr(0, mw(1, 1, 0, 9, 5) | 32'h8000_0001);
        rd(0, v);
        chk(v == mw(1, 1, 0, 9, 5), "R2 control readback", v, mw(1, 1, 0, 9, 5));

        // R3 R4 R5 sweep of every length code in both orders
        for (int code = 0; code < 16; code++) begin
            for (int mf = 0; mf < 2; mf++) begin
                tx = 32'hA5C3_96E1 ^ (32'(code) * 32'h0101_0101);
                xfer(0, mf[0], code, 0, tx, {tx[15:0], ~tx[31:16]} ^ 32'h3C3C_5A5A);
            end
        end

        // R7 loopback ignores miso (slave drives the complement)
        for (int code = 3; code < 16; code += 6) begin
            xfer(1, 1, code, 0, 32'h0000_B2D7, 32'hFFFF_4D28);
            xfer(1, 0, code, 0, 32'h1234_6E19, 32'hEDCB_91E6);
        end

        // R8 SCK period for several prescalers
        for (int p = 0; p < 4; p++) begin
            xfer(1, 1, 7, p, 32'h5A, 32'h0);
            chk((t_last - t_prev) == 4 * (p + 1), "R8 sck period", 32'(t_last - t_prev), 32'(4 * (p + 1)));
        end

        // R6 single-bit clear leaves the other flag
        wr(1, 32'h100);
        rd(1, v);
        chk(v == 32'h200, "R6 write-one clear", v, 32'h200);

        // R9 interrupt masking
        wr(1, 32'hFFFF_FFFF);
        xfer(0, 1, 7, 0, 32'h3C, 32'hC3);
        chk(!irq, "R9 zero mask", irq, 0);
        wr(2, 32'h200);
        chk(irq, "R9 rne enabled", irq, 1);
        wr(1, 32'h200);
        chk(!irq, "R9 tnf masked", irq, 0);
        wr(2, 32'h100);
        chk(irq, "R9 tnf enabled", irq, 1);
        wr(2, 0);

        // R10 overrun on second character
        setup(0, 1, 7, 0);
        arm(32'h11, 1, 8);
        wr(3, 32'h11);
        repeat (50) @(negedge clk);
        arm(32'h9E, 1, 8);
        wr(3, 32'h22);
        repeat (50) @(negedge clk);
        rd(1, v);
        chk(v == 32'h1300, "R10 overrun flag", v, 32'h1300);
        rd(4, v);
        chk(v == 32'h9E, "R10 newest data kept", v, 32'h9E);

        // R11 length and prescaler locked while enabled
        wr(0, mw(0, 1, 1, 15, 5));
        rd(0, v);
        chk(v == mw(0, 1, 1, 7, 0), "R11 locked fields", v, mw(0, 1, 1, 7, 0));

        // R13 transmit write while busy ignored
        setup(0, 1, 7, 0);
        arm(32'h0, 1, 8);
        wr(3, 32'hC5);
        repeat (5) @(negedge clk);
        wr(3, 32'h3A);
        wait_rne();
        chk(cap_w == 32'hC5, "R13 busy write ignored", cap_w, 32'hC5);

        // R12 abort mid transfer
        setup(0, 1, 15, 3);
        arm(32'hFFFF, 1, 16);
        wr(3, 32'hBEEF);
        repeat (40) @(negedge clk);
        wr(0, mw(0, 1, 0, 15, 3));
        repeat (2) @(negedge clk);
        chk(!sck && !mosi, "R12 pins idle after abort", {sck, mosi}, 0);
        rc = rise_cnt;
        repeat (400) @(negedge clk);
        chk(rise_cnt == rc, "R12 no more edges", 32'(rise_cnt), 32'(rc));
        rd(1, v);
        chk(v == 0, "R12 no events", v, 0);

        // R13 transmit write while disabled ignored
        arm(32'h0, 1, 16);
        wr(3, 32'h1234);
        repeat (300) @(negedge clk);
        chk(rise_cnt == 0, "R13 disabled write ignored", 32'(rise_cnt), 0);
        rd(1, v);
        chk(v == 0, "R13 no events when disabled", v, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule